// File: doc/BRIEF.md
# SPI Command Frame Receiver

This block is a serial slave front end. It takes fixed-length command words from an SPI master over four wires (select, clock, data in, data out) and passes each qualified word to a downstream command executor as a one-cycle strobe with the 24-bit word beside it. Each word is shifted in MSB first. Within the word, the top nibble is the opcode, the next nibble is a register address, and the low 16 bits are the payload.

The select line, the serial clock and the data input are resynchronised into the system clock and handled there. A bit counter runs modulo the frame length. When select is released, the counter decides what happens to the frame. A whole number of frames is executed. A count that is not a multiple of four is treated as noise and discarded. Any other count is kept, so the next selection can continue the word. A select pulse with no clock edges repeats the last executed word.

Bits that have passed through the shift register come out on the data output exactly one frame later. Several receivers can therefore be chained, each output feeding the next input. The output is released whenever the receiver is not selected.

Top module: `spi_frame_rx`

## Requirements
- R1: After reset, `cmd_valid` is low, `spi_miso_oe` is low, and the shift register is all zeros, so the first 24 bits shifted out after reset are 0.
- R2: A selection carrying exactly 24 clocks produces one `cmd_valid` pulse after select rises. `cmd_word` holds the bits in arrival order: the first bit is bit 23, the opcode is [23:20], the address is [19:16] and the payload is [15:0].
- R3: A selection carrying 48 clocks (any whole multiple of 24) produces one pulse, and `cmd_word` holds the last 24 bits received.
- R4: When select rises and the running bit count is not a multiple of 4 (for example 23 or 25 bits), no pulse is produced and both the count and the shift register are cleared to zero.
- R5: When select rises and the running count is a multiple of 4 but not of 24, no pulse is produced and the count and bits are kept. Clocks in a later selection continue the same word.
- R6: A select pulse with no clock edges re-issues the last executed word. Before any word has been executed since reset, such a pulse produces nothing.
- R7: Mode 0 (clock idles low, sample on the rising edge) and mode 3 (clock idles high, sample on the rising edge) give identical words.
- R8: `spi_miso_oe` is high while selected and low while not selected.
- R9: The data output before rising clock edge k shows the bit sampled 24 rising edges earlier, counted across selections. It changes only on falling clock edges and when select falls.
- R10: `cmd_valid` never stays high for two consecutive cycles.
- R11: If select rises in the same system-clock interval as the last rising clock edge, that edge is still counted and the frame is qualified with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Active-low select from the master |
| spi_sck | input | 1 | Serial clock (mode 0 or mode 3) |
| spi_mosi | input | 1 | Serial data in, MSB first |
| spi_miso | output | 1 | Serial data out (daisy chain), 0 when released |
| spi_miso_oe | output | 1 | High when the data output is driven |
| cmd_valid | output | 1 | One-cycle strobe for an executed or replayed word |
| cmd_word | output | 24 | Word handed to the executor |

## Verification
Two things can land in the same system cycle: the last rising serial clock edge, and the rising edge of select that closes the frame. The bench provokes this by driving both edges at the same instant, in mode 0 and in mode 3. The frame must still be judged on the full count, which means the word must come out with its final bit in place. The rest of the stimulus sweeps every selection length from 0 to 50 bits, back to back in both modes. A bench model tracks the running count, the kept bits and the last executed word, and judges every qualification outcome and every daisy-chained output bit against that model.

// File: rtl/spi_rx_pkg.sv
// Package: shared constants and types for the SPI command frame receiver.
// Assumes: frame length is a multiple of the noise-guard group size.
package spi_rx_pkg;

    localparam int FRAME_BITS_DEF = 24;
    localparam int GROUP_BITS_DEF = 4;
    localparam int SYNC_DEPTH_DEF = 2;

    // Outcome chosen for a selection when it closes.
    typedef enum logic [2:0] {
        QUAL_IDLE    = 3'd0,
        QUAL_ACCEPT  = 3'd1,
        QUAL_REPLAY  = 3'd2,
        QUAL_DISCARD = 3'd3,
        QUAL_HOLD    = 3'd4
    } qual_act_e;

    // Field view of a command word, opcode in the top nibble.
    typedef struct packed {
        logic [3:0]  opcode;
        logic [3:0]  addr;
        logic [15:0] payload;
    } cmd_fields_t;

endpackage

// File: rtl/spi_sync_edge.sv
// Module: spi_sync_edge
// Brings select, serial clock and data in into the system clock domain
// through SYNC_DEPTH flops each (the same depth for all three, so they stay
// aligned) and derives edge strobes. A serial clock edge counts only when the
// receiver was already selected, so edges seen while deselected, or on the
// very cycle select falls, have no effect.
// Assumes: serial clock at most clk/4; SYNC_DEPTH >= 2.
module spi_sync_edge #(
    parameter int SYNC_DEPTH = spi_rx_pkg::SYNC_DEPTH_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_in,
    input  logic sck_in,
    input  logic mosi_in,
    output logic cs_lvl,      // synchronised select, 1 = deselected
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise_ok,
    output logic sck_fall_ok,
    output logic mosi_s
);

    logic [SYNC_DEPTH-1:0] cs_pipe;
    logic [SYNC_DEPTH-1:0] sck_pipe;
    logic [SYNC_DEPTH-1:0] mosi_pipe;
    logic                  cs_prev;
    logic                  sck_prev;

    // Synchroniser chains; select resets to deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_pipe   <= '1;
            sck_pipe  <= '0;
            mosi_pipe <= '0;
        end else begin
            cs_pipe[0]   <= cs_n_in;
            sck_pipe[0]  <= sck_in;
            mosi_pipe[0] <= mosi_in;
            for (int i = 1; i < SYNC_DEPTH; i++) begin
                cs_pipe[i]   <= cs_pipe[i-1];
                sck_pipe[i]  <= sck_pipe[i-1];
                mosi_pipe[i] <= mosi_pipe[i-1];
            end
        end
    end

    // Previous synchronised levels, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            cs_prev  <= cs_pipe[SYNC_DEPTH-1];
            sck_prev <= sck_pipe[SYNC_DEPTH-1];
        end
    end

    // Edge strobes, with clock edges qualified by the prior select level.
    always_comb begin
        cs_lvl      = cs_pipe[SYNC_DEPTH-1];
        mosi_s      = mosi_pipe[SYNC_DEPTH-1];
        cs_fall     = !cs_lvl && cs_prev;
        cs_rise     = cs_lvl && !cs_prev;
        sck_rise_ok = sck_pipe[SYNC_DEPTH-1] && !sck_prev && !cs_prev;
        sck_fall_ok = !sck_pipe[SYNC_DEPTH-1] && sck_prev && !cs_prev;
    end

endmodule

// File: rtl/spi_shift_core.sv
// Module: spi_shift_core
// Holds the frame shift register, the bit counter (kept modulo FRAME_BITS)
// and the daisy-chain output register. The output register copies the
// oldest shift-register bit on each falling clock edge and when select
// falls, so that bit waits a full frame before it leaves.
// Assumes: discard never coincides with a sample (select is high then).
module spi_shift_core #(
    parameter int FRAME_BITS = spi_rx_pkg::FRAME_BITS_DEF,
    localparam int CNT_W     = $clog2(FRAME_BITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample,
    input  logic                  shift_out,
    input  logic                  cs_fall,
    input  logic                  mosi_s,
    input  logic                  discard,
    output logic [FRAME_BITS-1:0] shreg,
    output logic [CNT_W-1:0]      bit_cnt,
    output logic                  dout
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);

    // Shift register: new bits enter at bit 0; a discard clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || discard) begin
            shreg <= '0;
        end else if (sample) begin
            shreg <= {shreg[FRAME_BITS-2:0], mosi_s};
        end
    end

    // Bit counter modulo the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n || discard) begin
            bit_cnt <= '0;
        end else if (sample) begin
            bit_cnt <= (bit_cnt == CNT_LAST) ? '0 : bit_cnt + 1'b1;
        end
    end

    // Daisy-chain output register, loaded from the oldest bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= 1'b0;
        end else if (cs_fall || shift_out) begin
            dout <= shreg[FRAME_BITS-1];
        end
    end

    assert_discard_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        discard |=> (bit_cnt == '0 && shreg == '0));

    assert_shift_in_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !discard) |=> (shreg[0] == $past(mosi_s)));

    assert_dout_moves_on_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> $past(cs_fall || shift_out));

endmodule

// File: rtl/spi_frame_qual.sv
// Module: spi_frame_qual
// Decides what a selection meant once select has been released. The
// decision waits one cycle after the select rise, so a clock edge detected in
// the same cycle as that rise has already reached the counter. The module
// keeps the last executed word so it can replay it.
// Assumes: FRAME_BITS is a multiple of GROUP_BITS.
module spi_frame_qual
    import spi_rx_pkg::*;
#(
    parameter int FRAME_BITS = spi_rx_pkg::FRAME_BITS_DEF,
    parameter int GROUP_BITS = spi_rx_pkg::GROUP_BITS_DEF,
    localparam int CNT_W     = $clog2(FRAME_BITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_fall,
    input  logic                  cs_rise,
    input  logic                  sample,
    input  logic [CNT_W-1:0]      bit_cnt,
    input  logic [FRAME_BITS-1:0] shreg,
    output logic                  discard,
    output logic                  cmd_valid,
    output logic [FRAME_BITS-1:0] cmd_word
);

    logic                  rise_d;
    logic                  clk_seen;
    logic                  prev_valid;
    logic [FRAME_BITS-1:0] last_word;
    qual_act_e             act;

    // Delay the select rise by one cycle so the final edge has settled.
    always_ff @(posedge clk) begin
        if (!rst_n) rise_d <= 1'b0;
        else        rise_d <= cs_rise;
    end

    // Record whether this selection carried any clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_fall) clk_seen <= 1'b0;
        else if (sample)       clk_seen <= 1'b1;
    end

    // Choose the outcome for the selection that has just closed.
    always_comb begin
        act = QUAL_IDLE;
        if (rise_d) begin
            if (!clk_seen)
                act = prev_valid ? QUAL_REPLAY : QUAL_IDLE;
            else if (bit_cnt == '0)
                act = QUAL_ACCEPT;
            else if ((bit_cnt % CNT_W'(GROUP_BITS)) != '0)
                act = QUAL_DISCARD;
            else
                act = QUAL_HOLD;
        end
        discard = (act == QUAL_DISCARD);
    end

    // Remember the last executed word and that one exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_valid <= 1'b0;
            last_word  <= '0;
        end else if (act == QUAL_ACCEPT) begin
            prev_valid <= 1'b1;
            last_word  <= shreg;
        end
    end

    // Strobe and word towards the executor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_word  <= '0;
        end else begin
            cmd_valid <= (act == QUAL_ACCEPT) || (act == QUAL_REPLAY);
            if (act == QUAL_ACCEPT)      cmd_word <= shreg;
            else if (act == QUAL_REPLAY) cmd_word <= last_word;
        end
    end

    assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_strobe_implies_history_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> prev_valid);

    assert_decide_after_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> $past(rise_d));

endmodule

// File: rtl/spi_frame_rx.sv
// Module: spi_frame_rx (top)
// Joins the synchroniser, the shift core and the frame qualifier. The data
// output is driven only while the receiver is selected, and reads 0 when it
// is released.
// Assumes: serial clock at most clk/4, SPI mode 0 or mode 3.
module spi_frame_rx #(
    parameter int FRAME_BITS = spi_rx_pkg::FRAME_BITS_DEF,
    parameter int GROUP_BITS = spi_rx_pkg::GROUP_BITS_DEF,
    parameter int SYNC_DEPTH = spi_rx_pkg::SYNC_DEPTH_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_cs_n,
    input  logic                  spi_sck,
    input  logic                  spi_mosi,
    output logic                  spi_miso,
    output logic                  spi_miso_oe,
    output logic                  cmd_valid,
    output logic [FRAME_BITS-1:0] cmd_word
);

    localparam int CNT_W = $clog2(FRAME_BITS);

    logic                  cs_lvl;
    logic                  cs_fall;
    logic                  cs_rise;
    logic                  sck_rise_ok;
    logic                  sck_fall_ok;
    logic                  mosi_s;
    logic                  discard;
    logic                  dout;
    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      bit_cnt;

    spi_sync_edge #(.SYNC_DEPTH(SYNC_DEPTH)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_in     (spi_cs_n),
        .sck_in      (spi_sck),
        .mosi_in     (spi_mosi),
        .cs_lvl      (cs_lvl),
        .cs_fall     (cs_fall),
        .cs_rise     (cs_rise),
        .sck_rise_ok (sck_rise_ok),
        .sck_fall_ok (sck_fall_ok),
        .mosi_s      (mosi_s)
    );

    spi_shift_core #(.FRAME_BITS(FRAME_BITS)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (sck_rise_ok),
        .shift_out (sck_fall_ok),
        .cs_fall   (cs_fall),
        .mosi_s    (mosi_s),
        .discard   (discard),
        .shreg     (shreg),
        .bit_cnt   (bit_cnt),
        .dout      (dout)
    );

    spi_frame_qual #(.FRAME_BITS(FRAME_BITS), .GROUP_BITS(GROUP_BITS)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sample    (sck_rise_ok),
        .bit_cnt   (bit_cnt),
        .shreg     (shreg),
        .discard   (discard),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word)
    );

    // Drive the data output only while selected.
    always_comb begin
        spi_miso_oe = !cs_lvl;
        spi_miso    = spi_miso_oe && dout;
    end

    assert_released_output_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_miso_oe) |=> (spi_miso == 1'b0));

endmodule

// File: tb/tb_spi_frame_rx.sv
module tb_spi_frame_rx;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        spi_cs_n;
    logic        spi_sck;
    logic        spi_mosi;
    logic        spi_miso;
    logic        spi_miso_oe;
    logic        cmd_valid;
    logic [23:0] cmd_word;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    logic [23:0] got_word = '0;
    logic        prev_v = 1'b0;

    // Bench model of the receiver state, built from the requirements.
    logic [23:0] m_sh = '0;
    int          m_cnt = 0;
    bit          m_prev = 1'b0;
    logic [23:0] m_last = '0;
    logic [31:0] seed = 32'h1357_9bdf;

    always #2.5 clk = ~clk;

    spi_frame_rx dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_cs_n    (spi_cs_n),
        .spi_sck     (spi_sck),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe),
        .cmd_valid   (cmd_valid),
        .cmd_word    (cmd_word)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // Strobe monitor, sampled away from the active edge (R10).
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid) begin
                pulses++;
                got_word = cmd_word;
                chk("R10", "strobe longer than one cycle", {63'd0, prev_v}, 64'd0);
            end
            prev_v = cmd_valid;
        end
    end

    // One selection of n bits in mode 0 or 3; co raises select with the last edge.
    task automatic send_frame(input bit m3, input int n, input logic [63:0] v,
                              input bit co);
        int p0;
        bit ep;
        logic [23:0] ew;
        string tag;
        spi_sck = m3;
        repeat (3) @(negedge clk);
        p0 = pulses;
        spi_cs_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R8", "output enable while selected", {63'd0, spi_miso_oe}, 64'd1);
        for (int i = 0; i < n; i++) begin
            if (m3) spi_sck = 1'b0;
            spi_mosi = v[n-1-i];
            repeat (4) @(negedge clk);
            chk("R9", "daisy output before rising edge", {63'd0, spi_miso}, {63'd0, m_sh[23]});
            spi_sck = 1'b1;
            m_sh  = {m_sh[22:0], v[n-1-i]};
            m_cnt = (m_cnt == 23) ? 0 : m_cnt + 1;
            if (co && i == n - 1) spi_cs_n = 1'b1;
            repeat (4) @(negedge clk);
            if (!m3) spi_sck = 1'b0;
        end
        if (!spi_cs_n) begin
            repeat (2) @(negedge clk);
            spi_cs_n = 1'b1;
        end
        repeat (12) @(negedge clk);
        ep = 1'b0;
        ew = '0;
        if (n == 0) begin
            tag = "R6";
            ep = m_prev;
            ew = m_last;
        end else if (m_cnt == 0) begin
            tag = co ? "R11" : (n == 24) ? "R2" : (n % 24 == 0) ? "R3" : "R5";
            ep = 1'b1;
            ew = m_sh;
            m_last = m_sh;
            m_prev = 1'b1;
        end else if (m_cnt % 4 != 0) begin
            tag = "R4";
            m_sh = '0;
            m_cnt = 0;
        end else begin
            tag = "R5";
        end
        chk(tag, $sformatf("strobe count, %0d bits mode%0d", n, m3 ? 3 : 0),
            64'(pulses - p0), {63'd0, ep});
        if (ep)
            chk(tag, $sformatf("word, %0d bits mode%0d", n, m3 ? 3 : 0),
                {40'd0, got_word}, {40'd0, ew});
        chk("R8", "output released after deselect", {63'd0, spi_miso_oe}, 64'd0);
    endtask

    task automatic run_all();
        logic [23:0] w0;
        logic [63:0] v;
        spi_cs_n = 1'b1;
        spi_sck  = 1'b0;
        spi_mosi = 1'b0;
        rst_n    = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "strobe after reset", {63'd0, cmd_valid}, 64'd0);
        chk("R1", "output enable after reset", {63'd0, spi_miso_oe}, 64'd0);
        chk("R1", "data output after reset", {63'd0, spi_miso}, 64'd0);
        // Empty selection before any command: nothing replayed (R6).
        send_frame(1'b0, 0, 64'd0, 1'b0);
        // First 24 bits out after reset are zeros (R1 via R9 checks).
        send_frame(1'b0, 24, 64'h00a5_3c96, 1'b0);
        // Sweep of all lengths in both modes.
        for (int m = 0; m < 2; m++) begin
            for (int n = 0; n <= 50; n++) begin
                v = {next_rand(), next_rand()};
                send_frame(m[0], n, v, 1'b0);
            end
        end
        // Re-align the model to a frame boundary with a clean 25-bit discard.
        send_frame(1'b0, 25, 64'h1ff_ffff, 1'b0);
        if (m_cnt != 0) send_frame(1'b0, 1, 64'd1, 1'b0);
        // R7: same word in both modes.
        send_frame(1'b0, 24, 64'h0012_f0e1, 1'b0);
        w0 = got_word;
        send_frame(1'b1, 24, 64'h0012_f0e1, 1'b0);
        chk("R7", "mode 3 word equals mode 0 word", {40'd0, got_word}, {40'd0, w0});
        chk("R7", "field layout opcode/addr/payload", {40'd0, got_word}, 64'h12f0e1);
        // R6: replay after an executed word.
        send_frame(1'b1, 0, 64'd0, 1'b0);
        // R11: select rises with the last clock edge, both modes.
        send_frame(1'b0, 24, 64'h00c3_7a15, 1'b1);
        send_frame(1'b1, 24, 64'h005e_0b69, 1'b1);
        // R3 explicit: 48 bits keeps the last 24.
        send_frame(1'b1, 48, 64'hdead_be42_9c1f, 1'b0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                fails++;
                $display("FAIL watchdog (all requirements): actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule